// File: doc/BRIEF.md
# Block Transfer Sequencer

This block turns one decoded load-multiple or store-multiple instruction into a series of single-word memory transfers. It takes a 16-bit register-select mask, a direction (load or store), an addressing mode (increment or decrement, address stepped before or after) and the base address. It then issues one transfer per selected register and waits for the memory side to acknowledge each one. After the last transfer it pulses a completion flag together with the updated base value, and the register file may write that value back.

Registers always map to memory in ascending index order: the lowest selected register takes the lowest address. As a result, register 15 (the program counter) is always the last transfer when it is selected. The base value is captured when the instruction is accepted. A load that overwrites the base register therefore cannot disturb address generation, and a later change on the base input has no effect on a sequence already running.

Top module: `ldm_stm_seq`

## Requirements
- R1: When `start_i` is high while `busy_o` is low and the mask is non-zero, the block issues exactly one transfer per set mask bit (bit k selects register k). Transfers go in ascending register index, `xfer_idx_o` carries the register number, and `xfer_load_o` follows `load_i` (1 = load, 0 = store).
- R2: With `pre_i` (1 = step before, 0 = step after) and `up_i` (1 = increment, 0 = decrement), and with n the number of set mask bits, the first address is as follows: base+4 for pre=1,up=1; base for pre=0,up=1; base-4n for pre=1,up=0; base-4n+4 for pre=0,up=0. Each following transfer uses the previous address plus 4.
- R3: A transfer stays presented, with stable index, address and direction, until `xfer_done_i` is high at a rising clock edge. The next transfer is presented in the cycle after that edge.
- R4: One cycle after the last acknowledged transfer, `done_o` is high for exactly one cycle and `busy_o` drops in the following cycle. `wb_valid_o` equals the `wb_en_i` value captured at start and is high only while `done_o` is high. `wb_base_o` is base+4n for increment and base-4n for decrement.
- R5: A start with an all-zero mask issues no transfer and raises `done_o` in the cycle after the start edge, with `wb_base_o` equal to the base.
- R6: `s_bit_i` has no effect on any output.
- R7: The mask, mode bits and base are captured at the start edge. Changes on `base_i` or `reg_list_i`, and any `start_i` pulse, while `busy_o` is high leave the running sequence unchanged.
- R8: When register 15 is selected, it is the last transfer of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept a new instruction when idle |
| reg_list_i | input | 16 | Register-select mask |
| load_i | input | 1 | 1 = load, 0 = store |
| pre_i | input | 1 | 1 = step address before access |
| up_i | input | 1 | 1 = increment, 0 = decrement |
| wb_en_i | input | 1 | Request base writeback |
| s_bit_i | input | 1 | Mode-change flag, ignored |
| base_i | input | 32 | Base address |
| xfer_req_o | output | 1 | Transfer request |
| xfer_idx_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_load_o | output | 1 | Transfer direction, 1 = load |
| xfer_done_i | input | 1 | Memory acknowledge for the current transfer |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback strobe |
| wb_base_o | output | 32 | Updated base value |

## Verification
The first transfer is due one cycle after the start edge, and each later transfer one cycle after the acknowledging edge. `done_o` and the writeback outputs are due one cycle after the last acknowledge, or one cycle after start for an empty mask. The bench drives and samples on falling edges. It records a transfer only in the cycle in which it raises the acknowledge, and it looks for `done_o` at the falling edge that follows. For the empty mask, that must be the first falling edge after start. In stalled runs, the bench holds the acknowledge low for one cycle and compares the presented transfer across that stall.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic wb_en;
  } seq_mode_t;
endpackage

// File: rtl/ldm_bit_count.sv
module ldm_bit_count #(
  parameter int N     = 16,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] part [N+1];
  assign part[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_acc
    assign part[i+1] = part[i] + CNT_W'(vec_i[i]);
  end

  assign cnt_o = part[N];
endmodule

// File: rtl/ldm_low_pick.sv
module ldm_low_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  // clear lowest set bit
  assign rest_o = vec_i & (vec_i - N'(1));
endmodule

// File: rtl/ldm_addr_gen.sv
module ldm_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pre_i,
  input  logic              up_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] wb_base_o
);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] offs;

  assign span = ADDR_W'(cnt_i) * WORD;

  always_comb begin
    unique case ({pre_i, up_i})
      2'b11:   offs = WORD;
      2'b01:   offs = '0;
      2'b10:   offs = -span;
      default: offs = WORD - span;
    endcase
  end

  assign first_addr_o = base_i + offs;
  assign wb_base_o    = up_i ? base_i + span : base_i - span;
endmodule

// File: rtl/ldm_stm_seq.sv
module ldm_stm_seq
  import ldm_seq_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [NUM_REGS-1:0]         reg_list_i,
  input  logic                        load_i,
  input  logic                        pre_i,
  input  logic                        up_i,
  input  logic                        wb_en_i,
  input  logic                        s_bit_i,
  input  logic [ADDR_W-1:0]           base_i,
  output logic                        xfer_req_o,
  output logic [$clog2(NUM_REGS)-1:0] xfer_idx_o,
  output logic [ADDR_W-1:0]           xfer_addr_o,
  output logic                        xfer_load_o,
  input  logic                        xfer_done_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        wb_valid_o,
  output logic [ADDR_W-1:0]           wb_base_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int CNT_W = $clog2(NUM_REGS + 1);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(WORD_BYTES);
  localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(NUM_REGS - 1);

  seq_state_e          state_q;
  seq_mode_t           mode_q;
  logic [NUM_REGS-1:0] pend_q;
  logic [NUM_REGS-1:0] pend_rest;
  logic [ADDR_W-1:0]   addr_q;
  logic [ADDR_W-1:0]   wb_q;
  logic [CNT_W-1:0]    sel_cnt;
  logic [ADDR_W-1:0]   first_addr;
  logic [ADDR_W-1:0]   wb_calc;
  logic                accept;
  logic                unused_s_bit;

  // mode-change flag has no role here
  assign unused_s_bit = s_bit_i;

  ldm_bit_count #(.N(NUM_REGS), .CNT_W(CNT_W)) i_count (
    .vec_i (reg_list_i),
    .cnt_o (sel_cnt)
  );

  ldm_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) i_addr (
    .base_i       (base_i),
    .cnt_i        (sel_cnt),
    .pre_i        (pre_i),
    .up_i         (up_i),
    .first_addr_o (first_addr),
    .wb_base_o    (wb_calc)
  );

  ldm_low_pick #(.N(NUM_REGS), .IDX_W(IDX_W)) i_pick (
    .vec_i  (pend_q),
    .idx_o  (xfer_idx_o),
    .rest_o (pend_rest)
  );

  assign accept = (state_q == ST_IDLE) && start_i;

  // base and mask captured once; later loads cannot disturb them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      pend_q  <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mode_q  <= '{load: load_i, wb_en: wb_en_i};
            pend_q  <= reg_list_i;
            addr_q  <= first_addr;
            wb_q    <= wb_calc;
            state_q <= (reg_list_i == '0) ? ST_DONE : ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_done_i) begin
            pend_q <= pend_rest;
            addr_q <= addr_q + WORD;
            if (pend_rest == '0) state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_req_o  = (state_q == ST_XFER);
  assign xfer_addr_o = addr_q;
  assign xfer_load_o = mode_q.load;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign wb_valid_o  = done_o && mode_q.wb_en;
  assign wb_base_o   = wb_q;

  p_idx_ascend_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && xfer_done_i && pend_rest != '0) |=> (xfer_req_o && xfer_idx_o > $past(xfer_idx_o)));

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && xfer_done_i && pend_rest != '0) |=> (xfer_addr_o == $past(xfer_addr_o) + WORD));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_idx_o)
                                      && $stable(xfer_load_o)));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_wb_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);

  p_last_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && xfer_done_i && pend_rest == '0) |=> (done_o && !xfer_req_o));

  p_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && reg_list_i == '0) |=> (done_o && !xfer_req_o && wb_base_o == $past(base_i)));

  p_pc_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && xfer_done_i && xfer_idx_o == TOP_IDX) |=> !xfer_req_o);
endmodule

// File: tb/test_ldm_stm_seq.sv
module test_ldm_stm_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic        ld = 1'b0, pre = 1'b0, up = 1'b0, wb_en = 1'b0, s_bit = 1'b0;
  logic [31:0] base = '0;
  logic        xfer_req;
  logic [3:0]  xfer_idx;
  logic [31:0] xfer_addr;
  logic        xfer_load;
  logic        xfer_done = 1'b0;
  logic        busy, done, wb_valid;
  logic [31:0] wb_base;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ldm_stm_seq i_ldm_stm_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reg_list_i(reg_list),
    .load_i(ld), .pre_i(pre), .up_i(up), .wb_en_i(wb_en), .s_bit_i(s_bit),
    .base_i(base), .xfer_req_o(xfer_req), .xfer_idx_o(xfer_idx),
    .xfer_addr_o(xfer_addr), .xfer_load_o(xfer_load), .xfer_done_i(xfer_done),
    .busy_o(busy), .done_o(done), .wb_valid_o(wb_valid), .wb_base_o(wb_base)
  );

  // {mask, L, P, U, W, base}
  localparam logic [51:0] VEC [NV] = '{
    {16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_1000},
    {16'h8421, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_2000},
    {16'h00F0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_3000},
    {16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_4000},
    {16'h8003, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_5000},
    {16'h5555, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0100},
    {16'hA000, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_0000},
    {16'h0880, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0010}
  };

  logic [3:0]  rec_idx  [16];
  logic [31:0] rec_addr [16];
  logic        rec_load [16];
  int          n_rec;
  int          done_cyc;
  logic        got_wbv;
  logic [31:0] got_wb;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] m, input logic l, input logic p, input logic u,
                        input logic w, input logic s, input logic [31:0] b,
                        input bit stall, input bit disturb);
    bit stalled = 0;
    logic [31:0] h_addr = '0;
    logic [3:0]  h_idx = '0;
    n_rec = 0; done_cyc = -1; got_wbv = 0; got_wb = '0;
    @(negedge clk);
    reg_list = m; ld = l; pre = p; up = u; wb_en = w; s_bit = s; base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      base = ~b; reg_list = 16'h1234; ld = ~l; pre = ~p; up = ~u; wb_en = ~w;
    end
    for (int cyc = 0; cyc < 200; cyc++) begin
      start = disturb && (cyc == 1);
      if (done) begin
        done_cyc = cyc; got_wbv = wb_valid; got_wb = wb_base;
        chk(!xfer_req, "R4", "req low at done", {31'd0, xfer_req}, 32'd0);
        xfer_done = 1'b0;
        break;
      end
      if (xfer_req) begin
        if (stalled)
          chk(xfer_addr == h_addr && xfer_idx == h_idx, "R3", "held during stall",
              xfer_addr, h_addr);
        if (stall && !stalled) begin
          stalled = 1; h_addr = xfer_addr; h_idx = xfer_idx; xfer_done = 1'b0;
        end else begin
          stalled = 0;
          if (n_rec < 16) begin
            rec_idx[n_rec] = xfer_idx; rec_addr[n_rec] = xfer_addr; rec_load[n_rec] = xfer_load;
          end
          n_rec++;
          xfer_done = 1'b1;
        end
      end else begin
        xfer_done = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done_cyc >= 0, "R4", "done seen", done_cyc, 0);
    @(negedge clk);
    chk(!done && !busy, "R4", "done one cycle then idle", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic check_op(input logic [15:0] m, input logic l, input logic p, input logic u,
                          input logic w, input logic [31:0] b, input string tag);
    int cnt = 0;
    int pos = 0;
    logic [31:0] low, wbx;
    for (int k = 0; k < 16; k++) cnt += int'(m[k]);
    if (p && u)       low = b + 32'd4;
    else if (u)       low = b;
    else if (p)       low = b - 32'(4 * cnt);
    else              low = b - 32'(4 * cnt) + 32'd4;
    wbx = u ? b + 32'(4 * cnt) : b - 32'(4 * cnt);
    chk(n_rec == cnt, "R1", {tag, " transfer count"}, n_rec, cnt);
    for (int k = 0; k < 16; k++) begin
      if (m[k] && pos < n_rec && pos < 16) begin
        chk(rec_idx[pos] == 4'(k), "R1", {tag, " index"}, rec_idx[pos], k);
        chk(rec_load[pos] == l, "R1", {tag, " direction"}, rec_load[pos], l);
        chk(rec_addr[pos] == low + 32'(4 * pos), "R2", {tag, " address"},
            rec_addr[pos], low + 32'(4 * pos));
        pos++;
      end
    end
    chk(got_wbv == w, "R4", {tag, " wb strobe"}, got_wbv, w);
    chk(got_wb == wbx, "R4", {tag, " wb base"}, got_wb, wbx);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !xfer_req && !wb_valid, "R4", "reset state",
        {28'd0, busy, done, xfer_req, wb_valid}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][51:36], VEC[v][35], VEC[v][34], VEC[v][33], VEC[v][32], 1'b0,
             VEC[v][31:0], v[0], 1'b0);
      check_op(VEC[v][51:36], VEC[v][35], VEC[v][34], VEC[v][33], VEC[v][32],
               VEC[v][31:0], $sformatf("vec%0d", v));
    end

    // R5: empty mask completes in the cycle after start
    run_op(16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_7000, 1'b0, 1'b0);
    chk(done_cyc == 0, "R5", "empty done timing", done_cyc, 0);
    chk(n_rec == 0, "R5", "empty no transfer", n_rec, 0);
    chk(got_wb == 32'h0000_7000 && got_wbv, "R5", "empty wb base", got_wb, 32'h0000_7000);

    // R6: S bit set gives the same sequence
    run_op(16'h0C06, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0400, 1'b0, 1'b0);
    check_op(16'h0C06, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0400, "r6_sbit");

    // R7: inputs and start disturbed while busy
    run_op(16'h0F00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_9000, 1'b1, 1'b1);
    check_op(16'h0F00, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_9000, "r7_disturb");

    // R8: register 15 last on load with base register 0 also selected
    run_op(16'h8101, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0800, 1'b1, 1'b0);
    check_op(16'h8101, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0800, "r8_pc");
    chk(n_rec == 3 && rec_idx[2] == 4'd15, "R8", "pc last", rec_idx[2], 32'd15);

    summary();
  end
endmodule